// File: doc/BRIEF.md
# Circular Frame Buffer Scroll Address Unit

This unit tracks where the visible frame begins inside a circular region of video memory, so that the picture can be scrolled by moving a pointer instead of copying pixels. Software programs the base and size of the region, a physical offset, and which memory kind is fitted. It then issues commands. A scroll command moves the start pointer by a signed number of bytes. A home command parks the pointer at the base and returns the old position as a token. A restore command puts a saved token back.

The unit keeps the start pointer inside the region by wrapping it modulo the region size. The end address is always the start plus the region size. The fetch engine needs an initial address, a start address and an end pointer. The end pointer is backed off by one burst. All three are translated by the physical offset and are committed only on a vertical sync strobe, so the fetch engine never sees a half-updated frame.

Top module: `scroll_addr_unit`

## Requirements
- R1: A scroll command adds the signed offset to the start address. A result at or above base+size is reduced by size, and a result below base is increased by size.
- R2: A scroll offset whose magnitude exceeds the region size is rejected. `err_o` is 1 in the cycle after the command, and the start address is unchanged. A magnitude equal to the size is accepted.
- R3: `end_o` always equals `start_o` plus `cfg_size_i`.
- R4: The committed end pointer is the end address minus the burst size. The burst size is 16 bytes when `cfg_mem_kind_i` is 0 and `cfg_size_i`/1024 when it is 1.
- R5: On commit, `fe_init_o` and `fe_start_o` both take the start address minus `cfg_phys_off_i`. `fe_end_o` also has `cfg_phys_off_i` subtracted.
- R6: The three fetch-engine outputs change only on a clock edge where `vsync_i` is 1, and `fe_load_o` pulses for one cycle after that edge. A command in the same cycle as `vsync_i` is not seen by that commit: the commit latches the start address held before the command.
- R7: A home command (`cmd_op_i` = 1) sets the start address back to base. In the next cycle it presents the previous start address on `token_o`, with `token_valid_o` at 1 for one cycle.
- R8: A restore command (`cmd_op_i` = 2) loads the start address from `cmd_token_i`. Scroll uses `cmd_op_i` = 0. Op 3 does nothing.
- R9: After reset, `start_o` equals `cfg_base_i`, the fetch-engine outputs are 0, and `err_o`, `token_valid_o` and `fe_load_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_i | input | AW | Region base address |
| cfg_size_i | input | AW | Region size in bytes |
| cfg_phys_off_i | input | AW | Offset subtracted from committed addresses |
| cfg_mem_kind_i | input | 1 | 0: fixed 16-byte burst, 1: burst = size/1024 |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 scroll, 1 home, 2 restore, 3 none |
| cmd_offset_i | input | AW | Signed scroll offset in bytes |
| cmd_token_i | input | AW | Start address to restore |
| vsync_i | input | 1 | Vertical sync commit strobe |
| start_o | output | AW | Current start address |
| end_o | output | AW | Current end address |
| token_o | output | AW | Start address saved by the last home command |
| token_valid_o | output | 1 | Token presented this cycle |
| err_o | output | 1 | Scroll offset was rejected |
| fe_init_o | output | AW | Committed initial address |
| fe_start_o | output | AW | Committed start address |
| fe_end_o | output | AW | Committed end pointer |
| fe_load_o | output | 1 | Commit happened on the last edge |

## Verification
The hardest case to reach is a scroll command that arrives in the same cycle as the vertical sync strobe. The commit must then carry the old start address while the pointer itself moves. The bench drives both in one cycle and then checks both effects. It follows with a second strobe that must carry the new position. The wrap boundaries are reached by a chain of scrolls that sits exactly on base+size and base−1, and by offsets of exactly ±size and ±(size+1).

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  typedef enum logic [1:0] {
    OP_SCROLL  = 2'd0,
    OP_HOME    = 2'd1,
    OP_RESTORE = 2'd2,
    OP_IDLE    = 2'd3
  } scroll_op_e;

  localparam int unsigned FIXED_BURST_BYTES = 16;
  localparam int unsigned SIZE_DIV_SHIFT    = 10;
endpackage

// File: rtl/scroll_pos_track.sv
module scroll_pos_track #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [AW-1:0] cmd_offset_i,
  input  logic [AW-1:0] cmd_token_i,
  output logic [AW-1:0] pos_o,
  output logic [AW-1:0] token_o,
  output logic          token_valid_o,
  output logic          reject_o
);
  import scroll_pkg::*;

  localparam int unsigned EW = AW + 2;

  // magnitude of a signed offset, one bit wider so the most negative value fits
  function automatic logic [AW:0] off_mag(input logic [AW-1:0] off);
    if (off[AW-1]) return {1'b0, ~off} + {{AW{1'b0}}, 1'b1};
    else           return {1'b0, off};
  endfunction

  function automatic logic off_fits(input logic [AW-1:0] off, input logic [AW-1:0] size);
    return off_mag(off) <= {1'b0, size};
  endfunction

  // one-step circular add; valid when |off| <= size and pos < size
  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] pos,
                                             input logic [AW-1:0] off,
                                             input logic [AW-1:0] size);
    logic signed [EW-1:0] sum;
    logic signed [EW-1:0] sz;
    sz  = signed'({2'b00, size});
    sum = signed'({2'b00, pos}) + signed'({{2{off[AW-1]}}, off});
    if (sum >= sz)                  sum = sum - sz;
    else if (sum < signed'({EW{1'b0}})) sum = sum + sz;
    return sum[AW-1:0];
  endfunction

  logic          scroll_hit, home_hit, restore_hit, scroll_ok;
  logic [AW-1:0] next_scroll_pos;
  logic [AW-1:0] pos_q, token_q;
  logic          tv_q, rej_q;

  assign scroll_hit      = cmd_valid_i && (cmd_op_i == OP_SCROLL);
  assign home_hit        = cmd_valid_i && (cmd_op_i == OP_HOME);
  assign restore_hit     = cmd_valid_i && (cmd_op_i == OP_RESTORE);
  assign scroll_ok       = off_fits(cmd_offset_i, size_i);
  assign next_scroll_pos = wrap_add(pos_q, cmd_offset_i, size_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      token_q <= '0;
      tv_q    <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      tv_q  <= 1'b0;
      rej_q <= 1'b0;
      if (scroll_hit) begin
        if (scroll_ok) pos_q <= next_scroll_pos;
        else           rej_q <= 1'b1;
      end else if (home_hit) begin
        token_q <= base_i + pos_q;
        tv_q    <= 1'b1;
        pos_q   <= '0;
      end else if (restore_hit) begin
        pos_q <= cmd_token_i - base_i;
      end
    end
  end

  assign pos_o         = pos_q;
  assign token_o       = token_q;
  assign token_valid_o = tv_q;
  assign reject_o      = rej_q;

  AST_WRAP_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (scroll_hit && scroll_ok && pos_q < size_i) |=> (pos_q < $past(size_i))) // R1
    else $error("scroll left the region");

  AST_REJECT_KEEPS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (scroll_hit && !scroll_ok) |=> ($stable(pos_q) && reject_o)) // R2
    else $error("rejected scroll moved the pointer");

  AST_HOME_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    home_hit |=> (token_valid_o && pos_o == '0 && token_o == $past(base_i + pos_q))) // R7
    else $error("home command mishandled");
endmodule

// File: rtl/scroll_burst_sel.sv
module scroll_burst_sel #(
  parameter int unsigned AW          = 32,
  parameter int unsigned FIXED_BYTES = scroll_pkg::FIXED_BURST_BYTES,
  parameter int unsigned DIV_SHIFT   = scroll_pkg::SIZE_DIV_SHIFT
) (
  input  logic          mem_kind_i,
  input  logic [AW-1:0] size_i,
  output logic [AW-1:0] burst_o
);
  localparam logic [AW-1:0] FIXED_VAL = AW'(FIXED_BYTES);

  function automatic logic [AW-1:0] burst_of(input logic kind, input logic [AW-1:0] size);
    return kind ? (size >> DIV_SHIFT) : FIXED_VAL;
  endfunction

  assign burst_o = burst_of(mem_kind_i, size_i);
endmodule

// File: rtl/scroll_fe_commit.sv
module scroll_fe_commit #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vsync_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  input  logic [AW-1:0] burst_i,
  input  logic [AW-1:0] phys_off_i,
  output logic [AW-1:0] fe_init_o,
  output logic [AW-1:0] fe_start_o,
  output logic [AW-1:0] fe_end_o,
  output logic          fe_load_o
);
  function automatic logic [AW-1:0] to_phys(input logic [AW-1:0] a, input logic [AW-1:0] off);
    return a - off;
  endfunction

  logic [AW-1:0] init_q, start_q, end_q;
  logic          load_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q  <= '0;
      start_q <= '0;
      end_q   <= '0;
      load_q  <= 1'b0;
    end else begin
      load_q <= vsync_i;
      if (vsync_i) begin
        init_q  <= to_phys(start_i, phys_off_i);
        start_q <= to_phys(start_i, phys_off_i);
        end_q   <= to_phys(end_i - burst_i, phys_off_i);
      end
    end
  end

  assign fe_init_o  = init_q;
  assign fe_start_o = start_q;
  assign fe_end_o   = end_q;
  assign fe_load_o  = load_q;

  AST_HOLD_OUTSIDE_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_i |=> ($stable(fe_start_o) && $stable(fe_end_o) && $stable(fe_init_o) && !fe_load_o)) // R6
    else $error("fetch registers moved without vsync");

  AST_INIT_TRACKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_i |=> (fe_init_o == fe_start_o && fe_load_o)) // R5
    else $error("initial and start pointers differ");

  AST_END_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_i |=> (fe_end_o - fe_start_o == $past(end_i - burst_i - start_i))) // R4
    else $error("end pointer not one burst short");
endmodule

// File: rtl/scroll_addr_unit.sv
module scroll_addr_unit #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base_i,
  input  logic [AW-1:0] cfg_size_i,
  input  logic [AW-1:0] cfg_phys_off_i,
  input  logic          cfg_mem_kind_i,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [AW-1:0] cmd_offset_i,
  input  logic [AW-1:0] cmd_token_i,
  input  logic          vsync_i,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] end_o,
  output logic [AW-1:0] token_o,
  output logic          token_valid_o,
  output logic          err_o,
  output logic [AW-1:0] fe_init_o,
  output logic [AW-1:0] fe_start_o,
  output logic [AW-1:0] fe_end_o,
  output logic          fe_load_o
);
  logic [AW-1:0] pos_w, start_w, end_w, burst_w;

  scroll_pos_track #(.AW(AW)) pos_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .base_i       (cfg_base_i),
    .size_i       (cfg_size_i),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmd_op_i),
    .cmd_offset_i (cmd_offset_i),
    .cmd_token_i  (cmd_token_i),
    .pos_o        (pos_w),
    .token_o      (token_o),
    .token_valid_o(token_valid_o),
    .reject_o     (err_o)
  );

  assign start_w = cfg_base_i + pos_w;
  assign end_w   = start_w + cfg_size_i;

  scroll_burst_sel #(.AW(AW)) burst_i (
    .mem_kind_i(cfg_mem_kind_i),
    .size_i    (cfg_size_i),
    .burst_o   (burst_w)
  );

  scroll_fe_commit #(.AW(AW)) commit_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .vsync_i   (vsync_i),
    .start_i   (start_w),
    .end_i     (end_w),
    .burst_i   (burst_w),
    .phys_off_i(cfg_phys_off_i),
    .fe_init_o (fe_init_o),
    .fe_start_o(fe_start_o),
    .fe_end_o  (fe_end_o),
    .fe_load_o (fe_load_o)
  );

  assign start_o = start_w;
  assign end_o   = end_w;

  AST_END_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (end_o - start_o) == cfg_size_i) // R3
    else $error("end address span wrong");
endmodule

// File: tb/scroll_addr_unit_tb_top.sv
`timescale 1ns/1ps
module scroll_addr_unit_tb_top;
  localparam int AW = 32;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam logic [31:0] SIZE = 32'h0002_0000;
  localparam logic [31:0] PHYS = 32'h0008_0000;
  localparam int NV = 12;
  // {offset, expected position after command, expected err}
  localparam logic [64:0] VEC [NV] = '{
    {32'h0000_0100, 32'h0000_0100, 1'b0},
    {32'hFFFF_FE00, 32'h0001_FF00, 1'b0},
    {32'h0000_0100, 32'h0000_0000, 1'b0},
    {32'h0002_0000, 32'h0000_0000, 1'b0},
    {32'h0001_FFFF, 32'h0001_FFFF, 1'b0},
    {32'h0000_0001, 32'h0000_0000, 1'b0},
    {32'hFFFE_0000, 32'h0000_0000, 1'b0},
    {32'hFFFF_FFFF, 32'h0001_FFFF, 1'b0},
    {32'h0002_0001, 32'h0001_FFFF, 1'b1},
    {32'hFFFD_FFFF, 32'h0001_FFFF, 1'b1},
    {32'h0000_8000, 32'h0000_7FFF, 1'b0},
    {32'hFFFF_8001, 32'h0000_0000, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cfg_base, cfg_size, cfg_phys, cmd_offset, cmd_token;
  logic cfg_kind, cmd_valid, vsync;
  logic [1:0] cmd_op;
  logic [31:0] start_o, end_o, token_o, fe_init, fe_start, fe_end;
  logic token_valid, err, fe_load;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  scroll_addr_unit #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_base_i(cfg_base), .cfg_size_i(cfg_size),
    .cfg_phys_off_i(cfg_phys), .cfg_mem_kind_i(cfg_kind), .cmd_valid_i(cmd_valid),
    .cmd_op_i(cmd_op), .cmd_offset_i(cmd_offset), .cmd_token_i(cmd_token),
    .vsync_i(vsync), .start_o(start_o), .end_o(end_o), .token_o(token_o),
    .token_valid_o(token_valid), .err_o(err), .fe_init_o(fe_init),
    .fe_start_o(fe_start), .fe_end_o(fe_end), .fe_load_o(fe_load));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one command for one cycle; return at the negedge after its edge
  task automatic cmd(input logic [1:0] op, input logic [31:0] off, input logic [31:0] tok, input logic vs);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_offset = off; cmd_token = tok; vsync = vs;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3; vsync = 1'b0;
  endtask

  task automatic pulse_vsync();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] saved;
    cfg_base = BASE; cfg_size = SIZE; cfg_phys = PHYS; cfg_kind = 1'b1;
    cmd_valid = 1'b0; cmd_op = 2'd3; cmd_offset = '0; cmd_token = '0; vsync = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 start", start_o, BASE);
    chk("R9 fe_start", fe_start, 32'h0);
    chk("R9 fe_end", fe_end, 32'h0);
    chk("R9 flags", {29'd0, err, token_valid, fe_load}, 32'h0);
    chk("R3 end", end_o, BASE + SIZE);

    // vector walk: R1 wrap, R2 reject, R3 end
    for (int i = 0; i < NV; i++) begin
      cmd(2'd0, VEC[i][64:33], 32'h0, 1'b0);
      // sampled at the negedge right after the command edge (inside cmd before release would be same time)
      chk(VEC[i][0] ? "R2 start held" : "R1 start", start_o, BASE + VEC[i][32:1]);
      chk("R3 end", end_o, BASE + VEC[i][32:1] + SIZE);
    end

    // R2 err pulse check: rejected command, sample err in the cycle after
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_offset = 32'h0003_0000;
    @(negedge clk);
    chk("R2 err", {31'd0, err}, 32'd1);
    chk("R2 start unchanged", start_o, BASE);
    cmd_valid = 1'b0; cmd_op = 2'd3;
    @(negedge clk);
    chk("R2 err clears", {31'd0, err}, 32'd0);

    // R6 fetch outputs untouched by scrolling without vsync
    cmd(2'd0, 32'h0000_0400, 32'h0, 1'b0);
    chk("R6 no commit", fe_start, 32'h0);
    chk("R6 no load", {31'd0, fe_load}, 32'd0);

    // R5 / R4 commit with kind 1 (burst = size/1024 = 128)
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
    chk("R6 load pulse", {31'd0, fe_load}, 32'd1);
    chk("R5 fe_start", fe_start, BASE + 32'h400 - PHYS);
    chk("R5 fe_init", fe_init, BASE + 32'h400 - PHYS);
    chk("R4 fe_end kind1", fe_end, BASE + 32'h400 + SIZE - 32'd128 - PHYS);
    @(negedge clk);
    chk("R6 load one cycle", {31'd0, fe_load}, 32'd0);

    // R4 kind 0: burst 16
    cfg_kind = 1'b0;
    pulse_vsync();
    chk("R4 fe_end kind0", fe_end, BASE + 32'h400 + SIZE - 32'd16 - PHYS);

    // R6 command and vsync in the same cycle: commit sees old start
    cmd(2'd0, 32'h0000_0040, 32'h0, 1'b1);
    chk("R6 same-cycle commit old", fe_start, BASE + 32'h400 - PHYS);
    chk("R1 start moved", start_o, BASE + 32'h440);
    pulse_vsync();
    chk("R6 next commit new", fe_start, BASE + 32'h440 - PHYS);

    // R7 home: token returns old start, start back to base
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3;
    chk("R7 token", token_o, BASE + 32'h440);
    chk("R7 token valid", {31'd0, token_valid}, 32'd1);
    chk("R7 start base", start_o, BASE);
    saved = token_o;
    @(negedge clk);
    chk("R7 token valid pulse", {31'd0, token_valid}, 32'd0);
    chk("R6 home without vsync", fe_start, BASE + 32'h440 - PHYS);

    // R8 restore from token, and op 3 does nothing
    cmd(2'd0, 32'h0000_1000, 32'h0, 1'b0);
    cmd(2'd2, 32'h0, saved, 1'b0);
    chk("R8 restore", start_o, BASE + 32'h440);
    cmd(2'd3, 32'h0000_0800, BASE, 1'b0);
    chk("R8 idle op", start_o, BASE + 32'h440);

    // R1 wrap again after restore
    cmd(2'd0, SIZE - 32'h0000_0040, 32'h0, 1'b0);
    chk("R1 wrap high", start_o, BASE + 32'h400);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule